// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital timing controller of a successive-approximation converter. A free-running prescaler divides the system clock by a power of two chosen by a 3-bit select input. It produces a one-cycle ADC clock edge pulse and a mid-period pulse. A sequencer steps through each conversion on those pulses. It raises a one-cycle sample-and-hold strobe at the right point, captures the converted value into a result register when the conversion ends, and sets a sticky completion flag.

A conversion can be started in two ways. Software can raise a start request, or, with auto-triggering on, a rising edge on an external trigger line can start it. A triggered start resets the prescaler, so the time from the trigger to the sample is fixed. The first conversion after the block is enabled is a long one, used for analog warm-up. The comparator, the DAC, the input multiplexer and register decoding sit outside. The value to capture arrives on `sample_in`.

Top module: `adc_seq_top`

## Requirements
- R1: The prescaler is a 7-bit counter. It is cleared while `enable` is low and counts system clocks while `enable` is high, wrapping at 128. After the first clock edge that sees `enable` high it holds 1.
- R2: The divide ratio D is 2 for `div_sel` 0 and 1, and 2^`div_sel` for `div_sel` 2 to 7. An ADC clock edge is a system clock edge at which the low log2(D) counter bits are all ones. The mid-period point is the cycle in which those bits equal D/2-1.
- R3: A `start_req` pulse seen while enabled and idle raises `busy` at that edge. The conversion starts at the first ADC clock edge strictly after that edge.
- R4: A conversion ends L·D system clock edges after its start edge. L is 25 for the first conversion after enable and 13 otherwise.
- R5: A software-started conversion holds `sh_strobe` high for exactly one cycle, the mid-period cycle of ADC period S+1. That is the cycle after edge start+S·D+D/2-1, with S=13 for a first conversion and S=1 otherwise.
- R6: At the end edge, `result` takes `sample_in`, `done_flag` is set and `busy` falls.
- R7: `busy` stays high from the request edge until the end edge, whichever way the conversion was started.
- R8: `done_flag` stays set until `flag_clr` is high at an edge; a set at the same edge wins. A new conversion does not clear it.
- R9: Dropping `enable` returns the sequencer to idle at the next edge, abandoning any conversion without touching `result` or `done_flag`. It also re-arms the long first conversion.
- R10: A `start_req` or trigger edge while `busy` is high is ignored. It starts no second conversion and does not disturb the prescaler or the timing of the running conversion.
- R11: With `auto_en` high and the block idle, a rising `trig_in` first seen at edge a is accepted at edge a+2, after two synchronising flops and an edge-detect flop. At edge a+2 the prescaler restarts from 0, `busy` rises and the conversion starts. For a normal conversion `sh_strobe` is high in the cycle after edge a+2·D+1, on the second ADC edge, and the conversion ends at edge a+2+13·D.
- R12: A trigger edge while `auto_en` is low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low clears the prescaler and idles the sequencer |
| div_sel | input | 3 | Prescaler tap select |
| start_req | input | 1 | Software start request, one cycle |
| auto_en | input | 1 | Allows trigger edges to start conversions |
| trig_in | input | 1 | Asynchronous trigger source |
| flag_clr | input | 1 | Clears the completion flag |
| sample_in | input | 10 | Value captured at the end of a conversion |
| busy | output | 1 | Conversion requested or in progress |
| sh_strobe | output | 1 | One-cycle sample-and-hold strobe |
| result | output | 10 | Last captured conversion value |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Every divide select is swept. For each, the bench runs a first software conversion, then a normal one with a stray start in the middle, then a triggered conversion. The expected end and strobe edges are computed from the enable or trigger edge, so an error of one cycle or one ADC period in the start, sample or end point is caught. Both long and normal lengths are distinguished at each ratio. Separate patterns drop enable during a conversion, pulse the trigger with auto-triggering off, and clear the flag, which tells abort, re-arm, trigger gating and flag stickiness apart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int CNT_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             adc_tick,
  output logic             adc_mid
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   tap_tick, tap_mid;
  logic [SEL_W-1:0] tap_idx;

  always_comb begin
    if (!enable || restart) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tap_tick[0] = 1'b0;
  assign tap_mid[0]  = 1'b0;
  for (genvar g = 1; g <= CNT_W; g++) begin : g_tap
    assign tap_tick[g] = &cnt_q[g-1:0];
    if (g == 1) begin : g_low
      assign tap_mid[g] = ~cnt_q[0];
    end else begin : g_high
      assign tap_mid[g] = ~cnt_q[g-1] & (&cnt_q[g-2:0]);
    end
  end

  always_comb begin
    if (div_sel < SEL_W'(2)) tap_idx = SEL_W'(1);
    else                     tap_idx = div_sel;
  end

  assign adc_tick = enable & tap_tick[tap_idx];
  assign adc_mid  = enable & tap_mid[tap_idx];

  // R1
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));
  // R1
  presc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !restart) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_rise
);
  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], trig_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign trig_rise = sh_q[1] & ~sh_q[2];

  // R11
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25,
  parameter int NORM_SH   = 1,
  parameter int FIRST_SH  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             auto_en,
  input  logic             trig_rise,
  input  logic             adc_tick,
  input  logic             adc_mid,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] sample_in,
  output logic             presc_restart,
  output logic             busy,
  output logic             sh_strobe,
  output logic [RES_W-1:0] result,
  output logic             done_flag
);
  localparam int CYC_W = $clog2(FIRST_LEN + 1);
  localparam logic [CYC_W-1:0] NORM_LAST  = CYC_W'(NORM_LEN - 1);
  localparam logic [CYC_W-1:0] FIRST_LAST = CYC_W'(FIRST_LEN - 1);
  localparam logic [CYC_W-1:0] NORM_SP    = CYC_W'(NORM_SH);
  localparam logic [CYC_W-1:0] FIRST_SP   = CYC_W'(FIRST_SH);

  seq_st_e          st_q, st_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             first_q, first_d;
  logic             auto_q, auto_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             flag_q, flag_d;
  logic             take_trig, take_sw, last_cyc;

  assign take_trig = enable && auto_en && trig_rise && (st_q == ST_IDLE);
  assign take_sw   = enable && start_req && (st_q == ST_IDLE) && !take_trig;
  assign last_cyc  = first_q ? (cyc_q == FIRST_LAST) : (cyc_q == NORM_LAST);

  always_comb begin
    st_d    = st_q;
    cyc_d   = cyc_q;
    first_d = first_q;
    auto_d  = auto_q;
    res_d   = res_q;
    flag_d  = flag_q & ~flag_clr;
    if (!enable) begin
      st_d    = ST_IDLE;
      cyc_d   = '0;
      first_d = 1'b1;
      auto_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take_trig) begin
            st_d   = ST_CONV;
            cyc_d  = '0;
            auto_d = 1'b1;
          end else if (take_sw) begin
            st_d   = ST_WAIT;
            auto_d = 1'b0;
          end
        end
        ST_WAIT: begin
          if (adc_tick) begin
            st_d  = ST_CONV;
            cyc_d = '0;
          end
        end
        ST_CONV: begin
          if (adc_tick) begin
            if (last_cyc) begin
              st_d    = ST_IDLE;
              cyc_d   = '0;
              first_d = 1'b0;
              res_d   = sample_in;
              flag_d  = 1'b1;
            end else begin
              cyc_d = cyc_q + 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cyc_q   <= '0;
      first_q <= 1'b1;
      auto_q  <= 1'b0;
      res_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cyc_q   <= cyc_d;
      first_q <= first_d;
      auto_q  <= auto_d;
      res_q   <= res_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    sh_strobe = 1'b0;
    if (st_q == ST_CONV) begin
      if (first_q)     sh_strobe = (cyc_q == FIRST_SP) && adc_mid;
      else if (auto_q) sh_strobe = (cyc_q == NORM_SP) && adc_tick;
      else             sh_strobe = (cyc_q == NORM_SP) && adc_mid;
    end
  end

  assign presc_restart = take_trig;
  assign busy          = (st_q != ST_IDLE);
  assign result        = res_q;
  assign done_flag     = flag_q;

  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> busy);
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $fell(busy));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q == ST_CONV && adc_tick && enable) |=> $stable(res_q));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
  // R4
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV && enable && !adc_tick) |=> (st_q == ST_CONV && $stable(cyc_q)));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int CNT_W     = 7,
  parameter int SEL_W     = 3,
  parameter int RES_W     = 10,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25,
  parameter int NORM_SH   = 1,
  parameter int FIRST_SH  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             start_req,
  input  logic             auto_en,
  input  logic             trig_in,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             sh_strobe,
  output logic [RES_W-1:0] result,
  output logic             done_flag
);
  logic adc_tick, adc_mid, trig_rise, presc_restart;

  adc_prescaler #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(presc_restart),
    .div_sel(div_sel), .adc_tick(adc_tick), .adc_mid(adc_mid)
  );

  adc_trig_sync u_sync (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_rise(trig_rise)
  );

  adc_conv_seq #(
    .RES_W(RES_W), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN),
    .NORM_SH(NORM_SH), .FIRST_SH(FIRST_SH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_req(start_req),
    .auto_en(auto_en), .trig_rise(trig_rise), .adc_tick(adc_tick),
    .adc_mid(adc_mid), .flag_clr(flag_clr), .sample_in(sample_in),
    .presc_restart(presc_restart), .busy(busy), .sh_strobe(sh_strobe),
    .result(result), .done_flag(done_flag)
  );
endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n, enable, start_req, auto_en, trig_in, flag_clr;
  logic [2:0] div_sel;
  logic [9:0] sample_in, result;
  logic       busy, sh_strobe, done_flag;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int strobe_cnt = 0;
  int last_strobe = -1;
  int last_fall = -1;
  int origin = 0;
  bit prev_busy = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
    .start_req(start_req), .auto_en(auto_en), .trig_in(trig_in),
    .flag_clr(flag_clr), .sample_in(sample_in), .busy(busy),
    .sh_strobe(sh_strobe), .result(result), .done_flag(done_flag)
  );

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(posedge clk) begin
    #1;
    if (sh_strobe) begin
      strobe_cnt  = strobe_cnt + 1;
      last_strobe = ncyc;
    end
    if (prev_busy && !busy) last_fall = ncyc;
    prev_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int s);
    return (s < 2) ? 2 : (1 << s);
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic power_on(input int s);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    div_sel = 3'(s);
    enable  = 1'b1;
    origin  = ncyc;
  endtask

  // Software conversion; stray adds a start request mid-conversion (R10).
  task automatic sw_conv(input int d, input bit first, input int samp, input bit stray);
    int pw, pt, len, sp, s0;
    len = first ? 25 : 13;
    sp  = first ? 13 : 1;
    @(negedge clk);
    s0 = strobe_cnt;
    sample_in = 10'(samp);
    start_req = 1'b1;
    pw = ncyc + 1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy == 1'b1, "R3 busy after request", int'(busy), 1);
    pt = pw + (d - ((pw - origin) % d));
    if (stray) begin
      repeat (3 * d) @(negedge clk);
      start_req = 1'b1;
      trig_in   = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    wait_idle();
    trig_in = 1'b0;
    chk(last_fall == pt + len * d, "R4 end edge", last_fall, pt + len * d);
    chk(last_strobe == pt + sp * d + d / 2 - 1, "R5 strobe edge",
        last_strobe, pt + sp * d + d / 2 - 1);
    chk(strobe_cnt == s0 + 1, "R5 single strobe", strobe_cnt - s0, 1);
    chk(result == 10'(samp), "R6 result", int'(result), samp);
    chk(done_flag == 1'b1, "R6 R8 flag set", int'(done_flag), 1);
    if (stray) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R10 stray start ignored", int'(busy), 0);
      chk(strobe_cnt == s0 + 1, "R10 no extra strobe", strobe_cnt - s0, 1);
    end
  endtask

  task automatic auto_conv(input int d, input int samp);
    int a, g, s0;
    @(negedge clk);
    s0 = strobe_cnt;
    auto_en   = 1'b1;
    sample_in = 10'(samp);
    trig_in   = 1'b1;
    a = ncyc + 1;
    g = a + 2;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R11 not before sync", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b1, "R7 R11 busy on accept", int'(busy), 1);
    origin = g;
    wait_idle();
    trig_in = 1'b0;
    auto_en = 1'b0;
    chk(last_strobe == a + 2 * d + 1, "R11 trigger strobe edge", last_strobe, a + 2 * d + 1);
    chk(last_fall == g + 13 * d, "R11 trigger end edge", last_fall, g + 13 * d);
    chk(strobe_cnt == s0 + 1, "R11 single strobe", strobe_cnt - s0, 1);
    chk(result == 10'(samp), "R11 result", int'(result), samp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; start_req = 1'b0; auto_en = 1'b0;
    trig_in = 1'b0; flag_clr = 1'b0; div_sel = 3'd0; sample_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done_flag == 1'b0 && result == '0 && sh_strobe == 1'b0,
        "R6 reset state", {busy, done_flag, sh_strobe}, 0);

    // R12: trigger with auto-triggering off
    power_on(3);
    trig_in = 1'b1;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R12 trigger gated", int'(busy), 0);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);

    // R1 R2: sweep every select value
    for (int s = 0; s < 8; s++) begin
      int d;
      d = ratio(s);
      power_on(s);
      sw_conv(d, 1'b1, 17 * s + 3, 1'b0);
      sw_conv(d, 1'b0, 1023 - 29 * s, 1'b1);
      chk(done_flag == 1'b1, "R8 flag kept across conversion", int'(done_flag), 1);
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(done_flag == 1'b0, "R8 flag cleared", int'(done_flag), 1'b0);
      auto_conv(d, (s * 101) % 1024);
    end

    // R9: abort by dropping enable, then re-armed long conversion
    power_on(2);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9 abort idles", int'(busy), 0);
    chk(done_flag == 1'b0, "R9 flag untouched", int'(done_flag), 0);
    chk(result == 10'((7 * 101) % 1024), "R9 result untouched", int'(result), (7 * 101) % 1024);
    enable = 1'b1;
    origin = ncyc;
    sw_conv(4, 1'b1, 555, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule